// File: doc/BRIEF.md
# Serial Clock-Calendar Slave

The block is a clock-calendar peripheral reached over a three-wire, bit-banged serial link. A host toggles a strobe line, presents data on an input line and frames each exchange with an enable line. Every exchange is sixteen bits long. The first eight bits captured form a command code and the next eight form a data byte. A command in the read range makes the block shift the selected byte back out during the second half of the exchange. A command in the write range is acted on once the last bit arrives.

Readable sources are a scratch memory of 32 bytes, a status byte, a fixed control byte and six calendar fields held in BCD. The calendar advances on a one-second tick from elsewhere in the chip. A power event input raises an interrupt flag. The host clears that flag with a dedicated command. All host lines are sampled in the block's own clock domain and are treated as slow against it.

Top module: `rtc_serial_slave`

## Requirements
- R1: A bit is captured only in the cycle where the strobe is seen going from 1 to 0 while enable is 1. Strobe activity with enable at 0 leaves no trace in the next exchange.
- R2: Captured bits 1 to 8 build the command code and bits 9 to 16 build the data byte, each most significant bit first.
- R3: After captured bits 8 to 15, ser_data_oe is 1 and ser_data_o carries bits 7 down to 0 of the selected read byte. At all other times ser_data_oe is 0 and ser_data_o is 0.
- R4: Command codes 0x00 to 0x1F read the scratch byte at that index. After reset all scratch bytes are 0x00.
- R5: Code 0x30 reads the status byte, which resets to 0x90. Code 0x31 reads the control byte, fixed at the CTRL_INIT parameter (default 0x00).
- R6: Codes 0x20, 0x21, 0x22, 0x24, 0x25 and 0x26 read seconds, minutes, hours (0 to 23), day of month, month (1 to 12) and year offset from 2000, all in BCD. Codes 0x23, 0x27 to 0x2F and every other unlisted code below 0x80 read 0x00.
- R7: When the 16th bit is captured with a command of 0x80 to 0x9F, the data byte is stored at scratch index (command minus 0x80).
- R8: When the 16th bit is captured with command 0xB1 and data bit 2 set, status bits 4 and 3 clear and pwr_irq_o drops to 0. With data bit 2 clear the command changes nothing.
- R9: A cycle with pwr_event_i at 1 sets status bit 3 and pwr_irq_o. This wins over a clear in the same cycle.
- R10: Enable at 0 aborts the exchange: the bit count, command and data all return to zero. A partial write frame stores nothing.
- R11: Strobe edges after the 16th within one enable window are ignored until enable falls and rises again.
- R12: Each cycle with sec_tick_i at 1 advances the calendar by one second. It rolls over seconds, minutes, hours, days by month length with leap years (year offset divisible by 4), months and years.
- R13: After reset the calendar holds the INIT_* parameter values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk_i | input | 1 | Host serial strobe |
| ser_data_i | input | 1 | Host serial data in |
| ser_en_i | input | 1 | Host frame enable |
| sec_tick_i | input | 1 | One-second advance pulse |
| pwr_event_i | input | 1 | Power event, sets the interrupt flag |
| ser_data_o | output | 1 | Serial read data |
| ser_data_oe | output | 1 | Read data valid and driven |
| pwr_irq_o | output | 1 | Power interrupt request |

## Verification
On every cycle the assertions check several invariants. The bit count never passes sixteen. A low enable empties the frame. The power flag follows both its set event and its keyed clear. The seconds digits stay valid BCD, the month stays in 1 to 12, and the calendar stays still without a tick. The bench scenarios cover behaviour no single-cycle property can see: the full serial round trip of every read source, scratch contents after random writes and aborted frames, edges beyond the sixteenth, and the calendar crossing into a leap day and then into the next month.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int RAM_WORDS  = 32;
    localparam int RAM_AW     = $clog2(RAM_WORDS);
    localparam int BYTE_W     = 8;
    localparam int FRAME_BITS = 2 * BYTE_W;
    localparam int PHASE_W    = $clog2(FRAME_BITS + 1);

    localparam logic [7:0] CODE_SEC   = 8'h20;
    localparam logic [7:0] CODE_MIN   = 8'h21;
    localparam logic [7:0] CODE_HOUR  = 8'h22;
    localparam logic [7:0] CODE_DAY   = 8'h24;
    localparam logic [7:0] CODE_MON   = 8'h25;
    localparam logic [7:0] CODE_YEAR  = 8'h26;
    localparam logic [7:0] CODE_STAT  = 8'h30;
    localparam logic [7:0] CODE_CTRL  = 8'h31;
    localparam logic [7:0] CODE_CLR   = 8'hB1;
    localparam logic [7:0] CODE_WBASE = 8'h80;

    localparam int         CLR_KEY_BIT  = 2;
    localparam int         STAT_PWR_BIT = 3;
    localparam logic [7:0] STAT_CLR_MSK = 8'h18;

    typedef struct packed {
        logic [7:0] yr;
        logic [7:0] mon;
        logic [7:0] day;
        logic [7:0] hr;
        logic [7:0] min;
        logic [7:0] sec;
    } rtc_time_t;

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return v + 8'd1;
    endfunction

    function automatic logic is_leap(input logic [7:0] yr);
        if (!yr[4]) return (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
        return (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
    endfunction

    function automatic logic [7:0] last_day(input logic [7:0] mon, input logic [7:0] yr);
        case (mon)
            8'h02:                      return is_leap(yr) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction
endpackage

// File: rtl/rtc_frame_rx.sv
module rtc_frame_rx
    import rtc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk_i,
    input  logic               sdat_i,
    input  logic               en_i,
    output logic [PHASE_W-1:0] phase_o,
    output logic [BYTE_W-1:0]  cmd_o,
    output logic [BYTE_W-1:0]  dat_o,
    output logic               commit_o
);
    typedef struct packed {
        logic               sclk_prev;
        logic [PHASE_W-1:0] phase;
        logic [BYTE_W-1:0]  cmd;
        logic [BYTE_W-1:0]  dat;
        logic               commit;
    } rx_state_t;

    rx_state_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.sclk_prev = sclk_i;
        st_d.commit    = 1'b0;
        if (!en_i) begin
            st_d.phase = '0;
            st_d.cmd   = '0;
            st_d.dat   = '0;
        end else if (st_q.sclk_prev && !sclk_i && (st_q.phase < PHASE_W'(FRAME_BITS))) begin
            if (st_q.phase < PHASE_W'(BYTE_W)) st_d.cmd = {st_q.cmd[BYTE_W-2:0], sdat_i};
            else                               st_d.dat = {st_q.dat[BYTE_W-2:0], sdat_i};
            st_d.phase = st_q.phase + PHASE_W'(1);
            if (st_q.phase == PHASE_W'(FRAME_BITS - 1)) st_d.commit = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign phase_o  = st_q.phase;
    assign cmd_o    = st_q.cmd;
    assign dat_o    = st_q.dat;
    assign commit_o = st_q.commit;
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_pkg::*;
#(
    parameter logic [7:0] INIT_SEC  = 8'h00,
    parameter logic [7:0] INIT_MIN  = 8'h00,
    parameter logic [7:0] INIT_HOUR = 8'h00,
    parameter logic [7:0] INIT_DAY  = 8'h01,
    parameter logic [7:0] INIT_MON  = 8'h01,
    parameter logic [7:0] INIT_YEAR = 8'h00
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick_i,
    output rtc_time_t time_o
);
    localparam rtc_time_t TIME_RST = '{yr: INIT_YEAR, mon: INIT_MON, day: INIT_DAY,
                                       hr: INIT_HOUR, min: INIT_MIN, sec: INIT_SEC};

    rtc_time_t tm_d, tm_q;

    always_comb begin
        tm_d = tm_q;
        if (tick_i) begin
            if (tm_q.sec != 8'h59) begin
                tm_d.sec = bcd_inc(tm_q.sec);
            end else begin
                tm_d.sec = 8'h00;
                if (tm_q.min != 8'h59) begin
                    tm_d.min = bcd_inc(tm_q.min);
                end else begin
                    tm_d.min = 8'h00;
                    if (tm_q.hr != 8'h23) begin
                        tm_d.hr = bcd_inc(tm_q.hr);
                    end else begin
                        tm_d.hr = 8'h00;
                        if (tm_q.day != last_day(tm_q.mon, tm_q.yr)) begin
                            tm_d.day = bcd_inc(tm_q.day);
                        end else begin
                            tm_d.day = 8'h01;
                            if (tm_q.mon != 8'h12) begin
                                tm_d.mon = bcd_inc(tm_q.mon);
                            end else begin
                                tm_d.mon = 8'h01;
                                tm_d.yr  = (tm_q.yr == 8'h99) ? 8'h00 : bcd_inc(tm_q.yr);
                            end
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tm_q <= TIME_RST;
        else        tm_q <= tm_d;
    end

    assign time_o = tm_q;
endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
    import rtc_pkg::*;
#(
    parameter logic [7:0] STATUS_INIT = 8'h90,
    parameter logic [7:0] CTRL_INIT   = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] cmd_i,
    input  logic [BYTE_W-1:0] dat_i,
    input  logic              commit_i,
    input  logic              pwr_event_i,
    input  rtc_time_t         time_i,
    output logic [BYTE_W-1:0] rd_byte_o,
    output logic              irq_o
);
    typedef struct packed {
        logic [RAM_WORDS-1:0][BYTE_W-1:0] ram;
        logic [BYTE_W-1:0]                status;
        logic                             irq;
    } reg_state_t;

    localparam reg_state_t REG_RST = '{ram: '0, status: STATUS_INIT, irq: 1'b0};

    reg_state_t rf_d, rf_q;
    logic       is_ram_wr, is_ram_rd;

    assign is_ram_wr = (cmd_i[BYTE_W-1:RAM_AW] == CODE_WBASE[BYTE_W-1:RAM_AW]);
    assign is_ram_rd = (cmd_i[BYTE_W-1:RAM_AW] == '0);

    always_comb begin
        rf_d = rf_q;
        if (commit_i) begin
            if (is_ram_wr) rf_d.ram[cmd_i[RAM_AW-1:0]] = dat_i;
            if ((cmd_i == CODE_CLR) && dat_i[CLR_KEY_BIT]) begin
                rf_d.status = rf_q.status & ~STAT_CLR_MSK;
                rf_d.irq    = 1'b0;
            end
        end
        if (pwr_event_i) begin
            rf_d.status[STAT_PWR_BIT] = 1'b1;
            rf_d.irq                  = 1'b1;
        end
    end

    always_comb begin
        if (is_ram_rd) begin
            rd_byte_o = rf_q.ram[cmd_i[RAM_AW-1:0]];
        end else begin
            case (cmd_i)
                CODE_SEC:  rd_byte_o = time_i.sec;
                CODE_MIN:  rd_byte_o = time_i.min;
                CODE_HOUR: rd_byte_o = time_i.hr;
                CODE_DAY:  rd_byte_o = time_i.day;
                CODE_MON:  rd_byte_o = time_i.mon;
                CODE_YEAR: rd_byte_o = time_i.yr;
                CODE_STAT: rd_byte_o = rf_q.status;
                CODE_CTRL: rd_byte_o = CTRL_INIT;
                default:   rd_byte_o = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rf_q <= REG_RST;
        else        rf_q <= rf_d;
    end

    assign irq_o = rf_q.irq;
endmodule

// File: rtl/rtc_serial_slave.sv
module rtc_serial_slave
    import rtc_pkg::*;
#(
    parameter logic [7:0] INIT_SEC    = 8'h00,
    parameter logic [7:0] INIT_MIN    = 8'h00,
    parameter logic [7:0] INIT_HOUR   = 8'h00,
    parameter logic [7:0] INIT_DAY    = 8'h01,
    parameter logic [7:0] INIT_MON    = 8'h01,
    parameter logic [7:0] INIT_YEAR   = 8'h00,
    parameter logic [7:0] STATUS_INIT = 8'h90,
    parameter logic [7:0] CTRL_INIT   = 8'h00
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_clk_i,
    input  logic ser_data_i,
    input  logic ser_en_i,
    input  logic sec_tick_i,
    input  logic pwr_event_i,
    output logic ser_data_o,
    output logic ser_data_oe,
    output logic pwr_irq_o
);
    logic [PHASE_W-1:0] phase;
    logic [BYTE_W-1:0]  cmd;
    logic [BYTE_W-1:0]  dat;
    logic               commit;
    logic [BYTE_W-1:0]  rd_byte;
    rtc_time_t          now;

    rtc_frame_rx u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_i   (ser_clk_i),
        .sdat_i   (ser_data_i),
        .en_i     (ser_en_i),
        .phase_o  (phase),
        .cmd_o    (cmd),
        .dat_o    (dat),
        .commit_o (commit)
    );

    rtc_calendar #(
        .INIT_SEC (INIT_SEC),  .INIT_MIN (INIT_MIN),  .INIT_HOUR (INIT_HOUR),
        .INIT_DAY (INIT_DAY),  .INIT_MON (INIT_MON),  .INIT_YEAR (INIT_YEAR)
    ) u_cal (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (sec_tick_i),
        .time_o (now)
    );

    rtc_regfile #(
        .STATUS_INIT (STATUS_INIT),
        .CTRL_INIT   (CTRL_INIT)
    ) u_rf (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_i       (cmd),
        .dat_i       (dat),
        .commit_i    (commit),
        .pwr_event_i (pwr_event_i),
        .time_i      (now),
        .rd_byte_o   (rd_byte),
        .irq_o       (pwr_irq_o)
    );

    // Read window: bit counts 8..15, MSB first.
    logic [2:0] bit_sel;
    assign bit_sel     = ~phase[2:0];
    assign ser_data_oe = ser_en_i && (phase >= PHASE_W'(BYTE_W)) && (phase < PHASE_W'(FRAME_BITS));
    assign ser_data_o  = ser_data_oe ? rd_byte[bit_sel] : 1'b0;
endmodule

// File: rtl/rtc_serial_chk.sv
module rtc_serial_chk
    import rtc_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               ser_en_i,
    input logic               sec_tick_i,
    input logic               pwr_event_i,
    input logic               pwr_irq_o,
    input logic [PHASE_W-1:0] phase,
    input logic [BYTE_W-1:0]  cmd,
    input logic [BYTE_W-1:0]  dat,
    input logic               commit,
    input logic [7:0]         sec,
    input logic [7:0]         mon
);
    // R11
    phase_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase <= PHASE_W'(FRAME_BITS));

    // R10
    abort_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_en_i |=> (phase == '0) && (cmd == '0) && (dat == '0));

    // R7
    commit_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (phase == PHASE_W'(FRAME_BITS)));

    // R9
    irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_event_i |=> pwr_irq_o);

    // R8
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && (cmd == CODE_CLR) && dat[CLR_KEY_BIT] && !pwr_event_i) |=> !pwr_irq_o);

    // R12
    sec_bcd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec[3:0] <= 4'd9) && (sec[7:4] <= 4'd5));

    // R12
    mon_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mon >= 8'h01) && (mon <= 8'h12) && (mon[3:0] <= 4'd9));

    // R12
    sec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_tick_i |=> $stable(sec));
endmodule

bind rtc_serial_slave rtc_serial_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ser_en_i    (ser_en_i),
    .sec_tick_i  (sec_tick_i),
    .pwr_event_i (pwr_event_i),
    .pwr_irq_o   (pwr_irq_o),
    .phase       (phase),
    .cmd         (cmd),
    .dat         (dat),
    .commit      (commit),
    .sec         (now.sec),
    .mon         (now.mon)
);

// File: tb/rtc_serial_slave_bench.sv
module rtc_serial_slave_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk_i = 1'b0, ser_data_i = 1'b0, ser_en_i = 1'b0;
    logic sec_tick_i = 1'b0, pwr_event_i = 1'b0;
    logic ser_data_o, ser_data_oe, pwr_irq_o;

    always #10 clk = ~clk;

    rtc_serial_slave #(
        .INIT_SEC (8'h58), .INIT_MIN (8'h59), .INIT_HOUR (8'h23),
        .INIT_DAY (8'h28), .INIT_MON (8'h02), .INIT_YEAR (8'h24)
    ) u_rtc_serial_slave (.*);

    int checks = 0, fails = 0;
    bit finished = 1'b0;

    byte unsigned ram_m [32];
    byte unsigned status_m = 8'h90;
    bit           irq_m = 1'b0;
    int m_sec = 58, m_min = 59, m_hr = 23, m_day = 28, m_mon = 2, m_yr = 24;

    function automatic int to_bcd(input int v);
        return (v / 10) * 16 + (v % 10);
    endfunction

    function automatic int month_len(input int mo, input int yr);
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic void model_tick();
        m_sec++;
        if (m_sec == 60) begin m_sec = 0; m_min++; end
        if (m_min == 60) begin m_min = 0; m_hr++; end
        if (m_hr == 24) begin m_hr = 0; m_day++; end
        if (m_day > month_len(m_mon, m_yr)) begin m_day = 1; m_mon++; end
        if (m_mon == 13) begin m_mon = 1; m_yr = (m_yr + 1) % 100; end
    endfunction

    function automatic int exp_read(input int c);
        if (c < 32) return ram_m[c];
        case (c)
            'h20: return to_bcd(m_sec);
            'h21: return to_bcd(m_min);
            'h22: return to_bcd(m_hr);
            'h24: return to_bcd(m_day);
            'h25: return to_bcd(m_mon);
            'h26: return to_bcd(m_yr);
            'h30: return status_m;
            'h31: return 0;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Shift a frame of 'edges' strobe pulses; captures read bits and oe.
    task automatic shift(input logic [7:0] c, input logic [7:0] d, input int edges,
                         output logic [7:0] rd, output int oe_ok);
        rd = 8'h00;
        oe_ok = 1;
        ser_en_i = 1'b1;
        wait_clk(2);
        for (int i = 0; i < edges; i++) begin
            ser_data_i = (i < 8) ? c[7-i] : ((i < 16) ? d[15-i] : 1'b1);
            ser_clk_i = 1'b1;
            wait_clk(2);
            ser_clk_i = 1'b0;
            wait_clk(2);
            if (i >= 7 && i <= 14) begin
                rd[14-i] = ser_data_o;
                if (!ser_data_oe) oe_ok = 0;
            end else if (ser_data_oe || ser_data_o) begin
                oe_ok = 0;
            end
        end
    endtask

    task automatic end_frame();
        ser_en_i = 1'b0;
        ser_data_i = 1'b0;
        wait_clk(2);
    endtask

    task automatic rd_chk(input string req, input int c);
        logic [7:0] v;
        int ok;
        shift(8'(c), 8'h00, 16, v, ok);
        end_frame();
        chk(req, int'(v), exp_read(c));
        chk("R3 oe window", ok, 1);
    endtask

    task automatic wr(input int c, input int d);
        logic [7:0] v;
        int ok;
        shift(8'(c), 8'(d), 16, v, ok);
        end_frame();
        if (c >= 'h80 && c <= 'h9F) ram_m[c - 'h80] = 8'(d);
        if (c == 'hB1 && d[2]) begin status_m &= 8'hE7; irq_m = 1'b0; end
    endtask

    task automatic ticks(input int n);
        sec_tick_i = 1'b1;
        wait_clk(n);
        sec_tick_i = 1'b0;
        for (int i = 0; i < n; i++) model_tick();
        wait_clk(1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails + 0);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int ok;
        int seed;
        seed = $urandom(1234);
        foreach (ram_m[i]) ram_m[i] = 8'h00;
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(2);

        // R13 / R5 / R3 reset state
        chk("R3 reset oe", int'(ser_data_oe), 0);
        chk("R9 reset irq", int'(pwr_irq_o), 0);
        rd_chk("R5 status reset", 'h30);
        rd_chk("R5 control", 'h31);
        for (int c = 'h20; c <= 'h26; c++) rd_chk("R13 R6 init time", c);
        rd_chk("R4 ram reset", 'h00);
        rd_chk("R4 ram reset", 'h1F);

        // R6 unused codes
        rd_chk("R6 code 23", 'h23);
        for (int c = 'h27; c <= 'h2F; c++) rd_chk("R6 unused code", c);
        rd_chk("R6 code 40", 'h40);
        rd_chk("R6 code 7F", 'h7F);

        // R7 R4 R2 boundaries and random
        wr('h80, 'hA5);
        wr('h9F, 'h3C);
        rd_chk("R7 R4 idx0", 'h00);
        rd_chk("R7 R4 idx31", 'h1F);
        for (int n = 0; n < 40; n++) begin
            int c, d;
            c = 'h80 + int'($urandom_range(0, 31));
            d = int'($urandom_range(0, 255));
            wr(c, d);
            c = int'($urandom_range(0, 31));
            rd_chk("R2 R7 random ram", c);
        end
        for (int n = 0; n < 10; n++) rd_chk("R6 R4 random code", int'($urandom_range(0, 127)));

        // R1 strobe while disabled leaves no trace
        for (int i = 0; i < 8; i++) begin
            ser_data_i = 1'b1; ser_clk_i = 1'b1; wait_clk(2);
            ser_clk_i = 1'b0; wait_clk(2);
        end
        ser_data_i = 1'b0;
        rd_chk("R1 disabled strobe", 'h30);

        // R9 R8 interrupt flag
        @(negedge clk); pwr_event_i = 1'b1;
        @(negedge clk); pwr_event_i = 1'b0;
        status_m |= 8'h08; irq_m = 1'b1;
        wait_clk(1);
        chk("R9 irq set", int'(pwr_irq_o), 1);
        rd_chk("R9 status bit3", 'h30);
        wr('hB1, 'hFB);
        chk("R8 no key irq kept", int'(pwr_irq_o), 1);
        rd_chk("R8 no key status", 'h30);
        wr('hB1, 'h04);
        chk("R8 key irq clear", int'(pwr_irq_o), int'(irq_m));
        rd_chk("R8 key status", 'h30);

        // R10 abort mid write
        wr('h85, 'h11);
        shift(8'h85, 8'hEE, 12, v, ok);
        end_frame();
        rd_chk("R10 aborted write", 'h05);
        shift(8'h85, 8'hEE, 5, v, ok);
        end_frame();
        rd_chk("R10 restart after abort", 'h31);

        // R11 extra edges ignored
        shift(8'h86, 8'h5A, 22, v, ok);
        chk("R11 no oe after 16", int'(ser_data_oe), 0);
        end_frame();
        ram_m[6] = 8'h5A;
        rd_chk("R11 extra edges", 'h06);

        // R12 rollover into leap day, then into March
        ticks(1);
        rd_chk("R12 sec 59", 'h20);
        ticks(1);
        for (int c = 'h20; c <= 'h26; c++) rd_chk("R12 leap day", c);
        ticks(86400);
        for (int c = 'h20; c <= 'h26; c++) rd_chk("R12 month end", c);
        ticks(61);
        rd_chk("R12 sec", 'h20);
        rd_chk("R12 min", 'h21);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule